// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block holds the bytes that move between a host register port and a storage-bus controller when no DMA engine is involved. The host pushes bytes one at a time and pops them one at a time. A mode input selects where pushed bytes go. In normal operation they enter a small data buffer. That buffer has its own read and write pointers and a signed residual count, which tracks how many bytes the transfer still owes.

While the controller is collecting a command, the mode input diverts pushed bytes into a separate command buffer. That buffer keeps a length counter, and the controller reads it back by index. The controller can also preload a two-byte reply into the data buffer: a status byte followed by a zero byte. A sticky overrun flag records any byte that was refused. A flush input returns the pointers, the command length and the flag to their idle values.

The data buffer refuses a byte one slot before it is physically full. When the read pointer catches up with the write pointer, both pointers fall back to zero, so a drained buffer always restarts at slot zero.

Top module: `pio_byte_fifo`

## Requirements
- R1: After reset, rd_ptr, wr_ptr, resid, cmd_len, level and rd_data are 0 and ovr is 0.
- R2: With cmd_mode low, a push (wr_en) while wr_ptr is not DEPTH-1 stores wr_data at slot wr_ptr, advances wr_ptr by one and raises resid by one in the next cycle.
- R3: With cmd_mode low, a push while wr_ptr equals DEPTH-1 is dropped: ovr is set and wr_ptr, rd_ptr and resid keep their values, so the data buffer holds at most DEPTH-1 bytes.
- R4: With cmd_mode high, a push while cmd_len is below CMD_DEPTH stores the byte at command slot cmd_len and raises cmd_len by one; the data pointers and resid are unchanged.
- R5: With cmd_mode high, a push while cmd_len equals CMD_DEPTH is dropped, sets ovr and leaves cmd_len at CMD_DEPTH.
- R6: A pop (rd_en) with phase nonzero and rd_ptr below wr_ptr presents the byte at slot rd_ptr on rd_data in the next cycle, advances rd_ptr and lowers resid by one. A pop on an empty buffer changes nothing, and rd_data keeps its value.
- R7: Whenever the updated rd_ptr equals the updated wr_ptr, both pointers become 0.
- R8: A pop while phase is 3'b000 drives rd_data to 0 in the next cycle and moves no pointer or count.
- R9: rsp_load writes rsp_status into slot 0 and 0x00 into slot 1, and sets rd_ptr to 0, wr_ptr to 2, resid to 2 and level to 2. Pushes and pops in that cycle are ignored.
- R10: flush clears rd_ptr, wr_ptr, cmd_len and ovr and keeps resid. It takes priority over rsp_load, and both take priority over pushes and pops.
- R11: cmd_rd_data shows, without delay, the command byte stored at index cmd_rd_idx.
- R12: level always equals wr_ptr minus rd_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Clear pointers, command length and overrun flag |
| cmd_mode | input | 1 | 1: pushes go to the command buffer |
| phase | input | 3 | Bus phase bits; 000 blocks pops |
| wr_en | input | 1 | Push one byte |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop one byte |
| rd_data | output | 8 | Last popped byte (registered) |
| rsp_load | input | 1 | Preload status and zero byte |
| rsp_status | input | 8 | Status byte for the preload |
| cmd_rd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| cmd_rd_data | output | 8 | Command byte at cmd_rd_idx |
| rd_ptr | output | $clog2(DEPTH) | Data read pointer |
| wr_ptr | output | $clog2(DEPTH) | Data write pointer |
| level | output | $clog2(DEPTH) | Bytes waiting in the data buffer |
| resid | output | $clog2(DEPTH)+2 | Signed residual byte count |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Bytes held in the command buffer |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Every registered result of a push, pop, preload or flush is due one clock edge after the cycle in which the strobe is sampled. That covers the pointers, resid, cmd_len, ovr and rd_data. level follows the pointers in that same cycle, and cmd_rd_data follows cmd_rd_idx with no delay. The driver applies each strobe at a falling edge and drops it just after the next rising edge. Only then does it queue the expected values from its own model. The monitor compares them at the following falling edge, which is exactly one edge after the stimulus and half a period away from any update.

// File: rtl/pio_fifo_pkg.sv
// Shared types and constants for the programmed-I/O byte FIFO.
package pio_fifo_pkg;
    typedef logic [7:0] byte_t;
    localparam int    RSP_BYTES   = 2;      // bytes placed by a response preload
    localparam byte_t RSP_TRAILER = 8'h00;  // byte that follows the status byte
endpackage

// File: rtl/pio_data_store.sv
// Data byte storage for the FIFO.
// One indexed write port and one two-byte preload port that fills slots 0 and 1.
// Reads are combinational. Storage is not reset; the pointers decide validity.
// Assumes DEPTH >= 2 and that the caller never asserts we and ld together.
module pio_data_store
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  byte_t         wbyte,
    input  logic          ld,
    input  byte_t         ld_status,
    input  logic [PW-1:0] raddr,
    output byte_t         rbyte
);
    byte_t mem [DEPTH];

    // Write one slot per push, or the status/trailer pair on a preload.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (ld && i == 0)
                mem[i] <= ld_status;
            else if (ld && i == 1)
                mem[i] <= RSP_TRAILER;
            else if (we && waddr == PW'(i))
                mem[i] <= wbyte;
        end
    end

    // Present the slot addressed by the read pointer.
    assign rbyte = mem[raddr];
endmodule

// File: rtl/pio_cmd_store.sv
// Command capture buffer: append-only storage with a length counter.
// Appends past CMD_DEPTH are refused and reported on ovf in the same cycle.
// Assumes the caller gates app_en off in cycles it wants ignored.
module pio_cmd_store
    import pio_fifo_pkg::*;
#(
    parameter int CMD_DEPTH = 32,
    parameter int CW        = $clog2(CMD_DEPTH),
    parameter int LW        = $clog2(CMD_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          app_en,
    input  byte_t         app_byte,
    input  logic [CW-1:0] rd_idx,
    output byte_t         rd_byte,
    output logic [LW-1:0] len,
    output logic          ovf
);
    byte_t mem [CMD_DEPTH];
    logic  room;

    assign room = (len < LW'(CMD_DEPTH));
    assign ovf  = app_en && !flush && !room;

    // Track the number of captured bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            len <= '0;
        else if (app_en && room)
            len <= len + LW'(1);
    end

    // Store an accepted byte at the current length.
    always_ff @(posedge clk) begin
        if (app_en && room && !flush)
            mem[len[CW-1:0]] <= app_byte;
    end

    // Indexed read-back for the controller.
    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/pio_byte_fifo.sv
// Top of the programmed-I/O byte FIFO. Owns the data pointers, the residual
// count, the sticky overrun flag and the pop register, and steers pushes to the
// data or command store. Priority per cycle: flush, then preload, then push/pop.
// Assumes phase is 3'b000 only when the bus is in a phase with no data to pop.
module pio_byte_fifo
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int RW = $clog2(DEPTH) + 2,
    localparam int CW = $clog2(CMD_DEPTH),
    localparam int LW = $clog2(CMD_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 cmd_mode,
    input  logic [2:0]           phase,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic                 rd_en,
    output logic [7:0]           rd_data,
    input  logic                 rsp_load,
    input  logic [7:0]           rsp_status,
    input  logic [CW-1:0]        cmd_rd_idx,
    output logic [7:0]           cmd_rd_data,
    output logic [PW-1:0]        rd_ptr,
    output logic [PW-1:0]        wr_ptr,
    output logic [PW-1:0]        level,
    output logic signed [RW-1:0] resid,
    output logic [LW-1:0]        cmd_len,
    output logic                 ovr
);
    logic          idle_cycle;   // no flush or preload this cycle
    logic          data_wr, data_full, wr_ok, pop_ok, cmd_ovf;
    logic [PW-1:0] nxt_rp, nxt_wp;
    byte_t         head_byte;

    assign idle_cycle = !flush && !rsp_load;
    assign data_wr    = wr_en && !cmd_mode && idle_cycle;
    assign data_full  = (wr_ptr == PW'(DEPTH - 1));
    assign wr_ok      = data_wr && !data_full;
    assign pop_ok     = rd_en && idle_cycle && (phase != 3'b000) && (rd_ptr < wr_ptr);
    assign nxt_rp     = rd_ptr + PW'(pop_ok);
    assign nxt_wp     = wr_ptr + PW'(wr_ok);
    assign level      = wr_ptr - rd_ptr;

    pio_data_store #(.DEPTH(DEPTH), .PW(PW)) u_data (
        .clk       (clk),
        .we        (wr_ok),
        .waddr     (wr_ptr),
        .wbyte     (wr_data),
        .ld        (rsp_load && !flush),
        .ld_status (rsp_status),
        .raddr     (rd_ptr),
        .rbyte     (head_byte)
    );

    pio_cmd_store #(.CMD_DEPTH(CMD_DEPTH), .CW(CW), .LW(LW)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .app_en   (wr_en && cmd_mode && idle_cycle),
        .app_byte (wr_data),
        .rd_idx   (cmd_rd_idx),
        .rd_byte  (cmd_rd_data),
        .len      (cmd_len),
        .ovf      (cmd_ovf)
    );

    // Move the pointers, collapsing both to zero when they meet.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else if (rsp_load) begin
            rd_ptr <= '0;
            wr_ptr <= PW'(RSP_BYTES);
        end else if (nxt_rp == nxt_wp) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            rd_ptr <= nxt_rp;
            wr_ptr <= nxt_wp;
        end
    end

    // Keep the signed residual count; flush leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resid <= '0;
        else if (flush)
            resid <= resid;
        else if (rsp_load)
            resid <= RW'(RSP_BYTES);
        else
            resid <= resid + $signed({{(RW-1){1'b0}}, wr_ok})
                           - $signed({{(RW-1){1'b0}}, pop_ok});
    end

    // Sticky overrun flag for refused pushes in either mode.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ovr <= 1'b0;
        else if ((data_wr && data_full) || cmd_ovf)
            ovr <= 1'b1;
    end

    // Register the popped byte; a pop in a zero phase yields zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'h00;
        else if (rd_en && idle_cycle && phase == 3'b000)
            rd_data <= 8'h00;
        else if (pop_ok)
            rd_data <= head_byte;
    end
endmodule

// File: rtl/pio_byte_fifo_chk.sv
// Property checker for pio_byte_fifo, attached by bind below.
module pio_byte_fifo_chk #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int RW = $clog2(DEPTH) + 2,
    localparam int LW = $clog2(CMD_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 cmd_mode,
    input logic [2:0]           phase,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [7:0]           rd_data,
    input logic                 rsp_load,
    input logic [PW-1:0]        rd_ptr,
    input logic [PW-1:0]        wr_ptr,
    input logic [PW-1:0]        level,
    input logic signed [RW-1:0] resid,
    input logic [LW-1:0]        cmd_len,
    input logic                 ovr
);
    logic quiet;
    assign quiet = !flush && !rsp_load;

    // R2
    data_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && !cmd_mode && !rd_en && wr_ptr != PW'(DEPTH-1))
        |=> (wr_ptr == $past(wr_ptr) + PW'(1)) && (resid == $past(resid) + RW'(1)));

    // R3
    data_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && !cmd_mode && !rd_en && wr_ptr == PW'(DEPTH-1))
        |=> ovr && $stable(wr_ptr) && $stable(resid));

    // R4
    cmd_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && cmd_mode && cmd_len < LW'(CMD_DEPTH))
        |=> cmd_len == $past(cmd_len) + LW'(1));

    // R5
    cmd_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && cmd_mode && cmd_len == LW'(CMD_DEPTH))
        |=> ovr && cmd_len == LW'(CMD_DEPTH));

    // R6
    pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && rd_en && !(wr_en && !cmd_mode) && phase != 3'b000 && rd_ptr < wr_ptr)
        |=> resid == $past(resid) - RW'(1));

    // R7
    collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == wr_ptr) |-> (rd_ptr == '0));

    // R8
    zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && rd_en && !wr_en && phase == 3'b000)
        |=> rd_data == 8'h00 && $stable(rd_ptr) && $stable(resid));

    // R9
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_load && !flush)
        |=> rd_ptr == '0 && wr_ptr == PW'(2) && resid == RW'(2) && level == PW'(2));

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> rd_ptr == '0 && wr_ptr == '0 && cmd_len == '0 && !ovr && $stable(resid));

    // R12
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= wr_ptr);
endmodule

bind pio_byte_fifo pio_byte_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmd_mode(cmd_mode), .phase(phase),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rsp_load(rsp_load),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .level(level), .resid(resid),
    .cmd_len(cmd_len), .ovr(ovr)
);

// File: tb/sim_pio_byte_fifo.sv
// Scoreboard bench: driver tasks update a reference model and queue expected
// values; a monitor pops the queue on falling edges and compares.
module sim_pio_byte_fifo;
    localparam int D  = 16;
    localparam int CD = 32;
    localparam int PW = $clog2(D);
    localparam int RW = $clog2(D) + 2;
    localparam int CW = $clog2(CD);
    localparam int LW = $clog2(CD + 1);

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, cmd_mode = 1'b0;
    logic [2:0] phase = 3'b001;
    logic wr_en = 1'b0, rd_en = 1'b0, rsp_load = 1'b0;
    logic [7:0] wr_data = 8'h00, rsp_status = 8'h00;
    logic [CW-1:0] cmd_rd_idx = '0;
    logic [7:0] rd_data, cmd_rd_data;
    logic [PW-1:0] rd_ptr, wr_ptr, level;
    logic signed [RW-1:0] resid;
    logic [LW-1:0] cmd_len;
    logic ovr;

    always #10 clk = ~clk;  // 50 MHz

    pio_byte_fifo #(.DEPTH(D), .CMD_DEPTH(CD)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cmd_mode(cmd_mode), .phase(phase),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rsp_load(rsp_load), .rsp_status(rsp_status), .cmd_rd_idx(cmd_rd_idx),
        .cmd_rd_data(cmd_rd_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .level(level),
        .resid(resid), .cmd_len(cmd_len), .ovr(ovr)
    );

    typedef struct { int id; int val; string req; } exp_t;
    exp_t q[$];
    int total = 0, bad = 0;
    bit finished = 0;

    // reference model
    int m_rp = 0, m_wp = 0, m_resid = 0, m_clen = 0, m_ovr = 0, m_rdd = 0;
    int m_mem [D];
    int m_cmem [CD];

    function automatic int actual(int id);
        case (id)
            0: return int'(rd_ptr);
            1: return int'(wr_ptr);
            2: return int'(resid);
            3: return int'(cmd_len);
            4: return int'(ovr);
            5: return int'(rd_data);
            6: return int'(level);
            default: return int'(cmd_rd_data);
        endcase
    endfunction

    task automatic expect_all(string req);
        q.push_back('{0, m_rp, req});
        q.push_back('{1, m_wp, req});
        q.push_back('{2, m_resid, req});
        q.push_back('{3, m_clen, req});
        q.push_back('{4, m_ovr, req});
        q.push_back('{5, m_rdd, req});
        q.push_back('{6, m_wp - m_rp, req});
    endtask

    // Apply one strobe cycle, then queue the model's expected state.
    task automatic step(string req);
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; rsp_load = 0; flush = 0;
        expect_all(req);
    endtask

    task automatic push(input logic [7:0] b, string req);
        @(negedge clk);
        wr_en = 1; wr_data = b;
        if (cmd_mode) begin
            if (m_clen < CD) begin m_cmem[m_clen] = b; m_clen++; end
            else m_ovr = 1;
        end else if (m_wp == D - 1) m_ovr = 1;
        else begin m_mem[m_wp] = b; m_wp++; m_resid++; end
        step(req);
    endtask

    task automatic pop(string req);
        @(negedge clk);
        rd_en = 1;
        if (phase == 3'b000) m_rdd = 0;
        else if (m_rp < m_wp) begin
            m_rdd = m_mem[m_rp]; m_rp++; m_resid--;
            if (m_rp == m_wp) begin m_rp = 0; m_wp = 0; end
        end
        step(req);
    endtask

    task automatic preload(input logic [7:0] s, input bit with_flush, string req);
        @(negedge clk);
        rsp_load = 1; rsp_status = s; flush = with_flush;
        if (with_flush) begin m_rp = 0; m_wp = 0; m_clen = 0; m_ovr = 0; end
        else begin m_mem[0] = s; m_mem[1] = 0; m_rp = 0; m_wp = 2; m_resid = 2; end
        step(req);
    endtask

    task automatic do_flush(string req);
        @(negedge clk);
        flush = 1;
        m_rp = 0; m_wp = 0; m_clen = 0; m_ovr = 0;
        step(req);
    endtask

    task automatic check_cmd(int idx, string req);
        @(negedge clk);
        cmd_rd_idx = CW'(idx);
        #1;
        q.push_back('{7, m_cmem[idx], req});
    endtask

    // Monitor: compare queued expectations half a period after the update edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                int a;
                e = q.pop_front();
                a = actual(e.id);
                total++;
                if (a != e.val) begin
                    bad++;
                    $display("FAIL %s field=%0d actual=%0d expected=%0d", e.req, e.id, a, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        expect_all("R1 reset state");
        // R2 pushes, R6 pops in order, R7 collapse after last pop, R12 level
        push(8'hA1, "R2"); push(8'hB2, "R2 R12"); push(8'hC3, "R2");
        pop("R6"); pop("R6 R12"); pop("R6 R7 collapse");
        // R6 pop on empty buffer keeps rd_data and pointers
        pop("R6 empty pop");
        // R3 fill to DEPTH-1 then overrun
        for (int i = 0; i < D - 1; i++) push(8'(8'h10 + i), "R2 fill");
        push(8'hEE, "R3 overrun");
        push(8'hEF, "R3 second overrun");
        // R8 zero phase read returns 0 without popping
        phase = 3'b000;
        pop("R8 zero phase");
        phase = 3'b010;
        pop("R6 after zero phase");
        // R10 flush keeps resid, clears ptrs and ovr
        do_flush("R10 flush");
        // R4 command capture, data side untouched
        cmd_mode = 1;
        for (int i = 0; i < CD; i++) push(8'(8'h40 + i * 3), "R4 capture");
        push(8'h99, "R5 command overrun");
        check_cmd(0, "R11 first");
        check_cmd(7, "R11 middle");
        check_cmd(CD - 1, "R11 last");
        cmd_mode = 0;
        do_flush("R10 flush cmd");
        // R9 response preload and drain
        preload(8'h02, 1'b0, "R9 preload");
        pop("R9 status byte");
        pop("R9 trailer byte R7");
        // R10 flush wins over a simultaneous preload
        push(8'h5A, "R2");
        preload(8'h7F, 1'b1, "R10 flush over preload");
        push(8'h33, "R2 after flush");
        pop("R6 after flush");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule